// File: doc/BRIEF.md
# Speculative Chunk Conflict Detector with Bloom Signatures

A near-memory compute unit can run a chunk of work speculatively, with no coherence check on any single access, if something records what it touched and what the host changed over the same interval. This block keeps three fixed-size bit-vector signatures: one for cache-line addresses the near-memory unit reads, one for lines it writes, and one for lines the host writes. Each inserted address sets one bit per hash function. The signatures are lossy, so two different addresses can map to the same bits.

At the end of a chunk the controller raises `commit_req`. The block stops taking inserts, intersects the near-memory signatures with the host signature, and reports the outcome. A set conflict bit asks the surrounding logic to roll the chunk back. A clear bit means the chunk may commit. False positives are accepted: they cause rollbacks that were not needed but never hide a real overlap. After the controller acknowledges the report, all signatures clear in a single cycle and the next chunk begins.

Top module: `nmc_bloom_conflict`

## Requirements
- R1: After reset all three signatures are empty, `nm_ready` and `host_ready` are 1, and `res_valid` and `res_conflict` are 0.
- R2: An accepted address `a` (ADDR_W=32) sets bit `h_k(a)` of its signature for each k in 0..NUM_HASH-1 (default 2). The address is first rotated left by `k*HASH_STRIDE` bits (default stride 5, rotation taken modulo 32). Bit i of the rotated value is then XORed into bit `i mod 10` of the 10-bit index, which selects one of 1024 bits.
- R3: The report flags a conflict when the near-memory read signature shares any set bit with the host write signature.
- R4: The report flags a conflict when the near-memory write signature shares any set bit with the host write signature.
- R5: When neither near-memory signature shares a bit with the host signature, the report is clean (`res_conflict`=0). This includes an empty chunk.
- R6: Near-memory reads and writes that overlap each other, with no host writes to the same bits, do not cause a conflict.
- R7: `commit_req` sampled while running makes `res_valid` rise two clock edges later. `res_valid` and `res_conflict` then hold steady until `res_ack` is sampled high.
- R8: `nm_ready` and `host_ready` are 0 from the edge that accepts `commit_req` until the edge that samples `res_ack`. Inserts offered while they are 0 have no effect on any signature.
- R9: The edge that samples `res_ack` during a report clears all signatures and makes the block ready again, so the next chunk starts empty.
- R10: An insert accepted on the same edge as `commit_req` is part of that chunk's intersection.
- R11: Two distinct addresses whose hash indexes all coincide are reported as a conflict (false positive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nm_valid | input | 1 | Near-memory access to record |
| nm_write | input | 1 | 1 = write, 0 = read |
| nm_addr | input | ADDR_W | Near-memory cache-line address |
| nm_ready | output | 1 | Near-memory inserts are being accepted |
| host_valid | input | 1 | Host write to record |
| host_addr | input | ADDR_W | Host cache-line address |
| host_ready | output | 1 | Host inserts are being accepted |
| commit_req | input | 1 | End of chunk: start the check |
| res_valid | output | 1 | Check result is presented |
| res_conflict | output | 1 | 1 = rollback requested, 0 = clean commit |
| res_ack | input | 1 | Controller has taken the result |

## Verification
The bench sweeps several hundred chunks. In each chunk a read, a write and a host write go to generated addresses, and about a third of the chunks force an address to repeat. The expected verdict is computed from the hash definition. A wrong rotation or fold would disagree on the generated pairs, and a missing read or write path would miss the forced overlaps. Directed chunks cover three more cases:
- an insert that arrives with `commit_req`; dropping it would turn a rollback into a clean commit;
- host writes offered while the block is stalled; accepting them would poison the next chunk;
- a colliding pair of distinct addresses, which must roll back.

After each report the bench checks that nothing carries into the next chunk, which would show up as spurious rollbacks.

// File: rtl/nmc_bloom_pkg.sv
package nmc_bloom_pkg;
   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_CHECK  = 2'd1,
      PH_REPORT = 2'd2
   } phase_e;
endpackage

// File: rtl/nmc_sig_hash.sv
// One hash lane: rotate the line address, then XOR-fold it down to an index.
module nmc_sig_hash #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int ROT    = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int ROT_M = ROT % ADDR_W;

   logic [ADDR_W-1:0] rot_addr;

   generate
      if (ROT_M == 0) begin : g_norot
         assign rot_addr = addr;
      end else begin : g_rot
         assign rot_addr = {addr[ADDR_W-1-ROT_M:0], addr[ADDR_W-1:ADDR_W-ROT_M]};
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         idx[i % IDX_W] = idx[i % IDX_W] ^ rot_addr[i];
      end
   end
endmodule

// File: rtl/nmc_sig_vec.sv
// One Bloom signature register: set bits on insert, clear all bits at once.
module nmc_sig_vec #(
   parameter int SIG_BITS = 1024,
   parameter int IDX_W    = 10,
   parameter int NUM_HASH = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ins,
   input  logic                      clr,
   input  logic [NUM_HASH*IDX_W-1:0] idx_flat,
   output logic [SIG_BITS-1:0]       sig
);
   logic [SIG_BITS-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      for (int k = 0; k < NUM_HASH; k++) begin
         set_mask[idx_flat[k*IDX_W +: IDX_W]] = ins;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sig <= '0;
      else if (clr) sig <= '0;
      else          sig <= sig | set_mask;
   end

   // R2: the first hash lane's bit is set after an insert
   assert_insert_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ins && !clr |=> sig[$past(idx_flat[IDX_W-1:0])]);
   // R2: an insert never clears bits that were already set
   assert_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((sig & $past(sig)) == $past(sig)));
endmodule

// File: rtl/nmc_bloom_conflict.sv
// Collects read, write and host-write signatures for a speculative chunk
// and reports a conflict or a clean commit at the chunk boundary.
module nmc_bloom_conflict
   import nmc_bloom_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SIG_BITS    = 1024,
   parameter int NUM_HASH    = 2,
   parameter int HASH_STRIDE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nm_valid,
   input  logic              nm_write,
   input  logic [ADDR_W-1:0] nm_addr,
   output logic              nm_ready,
   input  logic              host_valid,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              host_ready,
   input  logic              commit_req,
   output logic              res_valid,
   output logic              res_conflict,
   input  logic              res_ack
);
   localparam int IDX_W = $clog2(SIG_BITS);

   generate
      if ((1 << IDX_W) != SIG_BITS) begin : g_bad_size
         $error("SIG_BITS must be a power of two");
      end
      if (NUM_HASH < 1) begin : g_bad_hash
         $error("NUM_HASH must be at least one");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("ADDR_W must cover the signature index width");
      end
   endgenerate

   phase_e phase_q;
   logic   conflict_q;

   logic [NUM_HASH*IDX_W-1:0] nm_idx, host_idx;
   logic [SIG_BITS-1:0]       sig_rd, sig_wr, sig_host;

   logic running, nm_fire, host_fire, clear_all;

   assign running    = (phase_q == PH_RUN);
   assign nm_fire    = nm_valid && running;
   assign host_fire  = host_valid && running;
   assign clear_all  = (phase_q == PH_REPORT) && res_ack;

   generate
      for (genvar k = 0; k < NUM_HASH; k++) begin : g_lane
         nmc_sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT(k*HASH_STRIDE)) i_nm_hash (
            .addr (nm_addr),
            .idx  (nm_idx[k*IDX_W +: IDX_W])
         );
         nmc_sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT(k*HASH_STRIDE)) i_host_hash (
            .addr (host_addr),
            .idx  (host_idx[k*IDX_W +: IDX_W])
         );
      end
   endgenerate

   nmc_sig_vec #(.SIG_BITS(SIG_BITS), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) i_sig_rd (
      .clk(clk), .rst_n(rst_n), .ins(nm_fire && !nm_write), .clr(clear_all),
      .idx_flat(nm_idx), .sig(sig_rd)
   );
   nmc_sig_vec #(.SIG_BITS(SIG_BITS), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) i_sig_wr (
      .clk(clk), .rst_n(rst_n), .ins(nm_fire && nm_write), .clr(clear_all),
      .idx_flat(nm_idx), .sig(sig_wr)
   );
   nmc_sig_vec #(.SIG_BITS(SIG_BITS), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) i_sig_host (
      .clk(clk), .rst_n(rst_n), .ins(host_fire), .clr(clear_all),
      .idx_flat(host_idx), .sig(sig_host)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_RUN;
         conflict_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_RUN:    if (commit_req) phase_q <= PH_CHECK;
            PH_CHECK: begin
               conflict_q <= |((sig_rd | sig_wr) & sig_host);
               phase_q    <= PH_REPORT;
            end
            PH_REPORT: if (res_ack) phase_q <= PH_RUN;
            default:   phase_q <= PH_RUN;
         endcase
      end
   end

   assign nm_ready     = running;
   assign host_ready   = running;
   assign res_valid    = (phase_q == PH_REPORT);
   assign res_conflict = conflict_q;

   assert_stall_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      nm_ready && commit_req |=> !nm_ready && !host_ready);
   assert_frozen_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !nm_ready && !(res_valid && res_ack) |=>
         $stable(sig_rd) && $stable(sig_wr) && $stable(sig_host));
   assert_report_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nm_ready && commit_req |=> ##1 res_valid);
   assert_report_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ack |=> res_valid && $stable(res_conflict));
   assert_clear_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_ack |=> nm_ready && ((sig_rd | sig_wr | sig_host) == '0));
endmodule

// File: tb/test_nmc_bloom_conflict.sv
module test_nmc_bloom_conflict;
   localparam int AW = 32;
   localparam int SB = 1024;
   localparam int IW = 10;
   localparam int NH = 2;
   localparam int ST = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nm_valid = 1'b0, nm_write = 1'b0, host_valid = 1'b0;
   logic commit_req = 1'b0, res_ack = 1'b0;
   logic [AW-1:0] nm_addr = '0, host_addr = '0;
   logic nm_ready, host_ready, res_valid, res_conflict;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [SB-1:0] m_rd, m_wr, m_host;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   nmc_bloom_conflict #(.ADDR_W(AW), .SIG_BITS(SB), .NUM_HASH(NH), .HASH_STRIDE(ST)) i_nmc_bloom_conflict (
      .clk(clk), .rst_n(rst_n),
      .nm_valid(nm_valid), .nm_write(nm_write), .nm_addr(nm_addr), .nm_ready(nm_ready),
      .host_valid(host_valid), .host_addr(host_addr), .host_ready(host_ready),
      .commit_req(commit_req), .res_valid(res_valid), .res_conflict(res_conflict),
      .res_ack(res_ack)
   );

   function automatic logic [IW-1:0] bhash(input logic [AW-1:0] a, input int k);
      int s;
      logic [AW-1:0] r;
      logic [IW-1:0] h;
      s = (k * ST) % AW;
      r = (s == 0) ? a : ((a << s) | (a >> (AW - s)));
      h = '0;
      for (int i = 0; i < AW; i++) h[i % IW] = h[i % IW] ^ r[i];
      return h;
   endfunction

   function automatic logic [SB-1:0] bmask(input logic [AW-1:0] a);
      logic [SB-1:0] m;
      m = '0;
      for (int k = 0; k < NH; k++) m[bhash(a, k)] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      return x * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      m_rd = '0; m_wr = '0; m_host = '0;
   endtask

   // one cycle of near-memory insert; called right after a falling edge
   task automatic nm_put(input logic [AW-1:0] a, input logic w);
      nm_valid = 1'b1; nm_write = w; nm_addr = a;
      @(negedge clk);
      nm_valid = 1'b0;
      if (w) m_wr = m_wr | bmask(a); else m_rd = m_rd | bmask(a);
   endtask

   task automatic host_put(input logic [AW-1:0] a);
      host_valid = 1'b1; host_addr = a;
      @(negedge clk);
      host_valid = 1'b0;
      m_host = m_host | bmask(a);
   endtask

   // commit; optional host insert on the commit edge (R10) or while stalled (R8)
   task automatic commit_chunk(input string req, input bit with_host, input logic [AW-1:0] ha,
                               input bit stall_host, input logic [AW-1:0] sa);
      logic exp_c;
      commit_req = 1'b1;
      if (with_host) begin
         host_valid = 1'b1; host_addr = ha;
         m_host = m_host | bmask(ha);
      end
      exp_c = |((m_rd | m_wr) & m_host);
      @(negedge clk);
      commit_req = 1'b0; host_valid = 1'b0;
      chk("R8 ready low in check", {30'd0, nm_ready, host_ready}, 32'd0);
      chk("R7 no result during check", {31'd0, res_valid}, 32'd0);
      if (stall_host) begin
         host_valid = 1'b1; host_addr = sa;
         nm_valid = 1'b1; nm_write = 1'b0; nm_addr = sa;
      end
      @(negedge clk);
      chk("R7 result valid", {31'd0, res_valid}, 32'd1);
      chk(req, {31'd0, res_conflict}, {31'd0, exp_c});
      @(negedge clk);
      chk("R7 result held", {30'd0, res_valid, res_conflict}, {30'd0, 1'b1, exp_c});
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0; host_valid = 1'b0; nm_valid = 1'b0;
      chk("R9 ready after ack", {30'd0, nm_ready, res_valid}, 32'd2);
      model_clear();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a, b, c;
      model_clear();
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {28'd0, nm_ready, host_ready, res_valid, res_conflict}, 32'hC);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", {30'd0, nm_ready, host_ready}, 32'd3);

      // R5 empty chunk is clean
      commit_chunk("R5 empty chunk", 1'b0, '0, 1'b0, '0);

      // R3 read vs host write, same line
      nm_put(32'h0000_1040, 1'b0);
      host_put(32'h0000_1040);
      commit_chunk("R3 read-host overlap", 1'b0, '0, 1'b0, '0);

      // R4 write vs host write, same line
      nm_put(32'h00AB_CDE0, 1'b1);
      host_put(32'h00AB_CDE0);
      commit_chunk("R4 write-host overlap", 1'b0, '0, 1'b0, '0);

      // R6 near-memory read and write of the same line, no host
      nm_put(32'h0000_0777, 1'b0);
      nm_put(32'h0000_0777, 1'b1);
      commit_chunk("R6 nm-only overlap", 1'b0, '0, 1'b0, '0);

      // R5 disjoint lines (expected from hash model)
      nm_put(32'h0000_0001, 1'b0);
      host_put(32'h0000_0002);
      commit_chunk("R5 disjoint lines", 1'b0, '0, 1'b0, '0);

      // R10 host write on commit edge conflicts with earlier read
      nm_put(32'h0055_0000, 1'b0);
      commit_chunk("R10 insert on commit edge", 1'b1, 32'h0055_0000, 1'b0, '0);

      // R8 host write offered while stalled, then R9 next chunk clean
      nm_put(32'h0033_3000, 1'b0);
      commit_chunk("R8 stall chunk", 1'b0, '0, 1'b1, 32'h0099_9000);
      nm_put(32'h0099_9000, 1'b0);
      commit_chunk("R8 stalled insert ignored", 1'b0, '0, 1'b0, '0);
      host_put(32'h0000_1040);
      commit_chunk("R9 signatures cleared", 1'b0, '0, 1'b0, '0);

      // R11 false positive: flip bits 0 and 10, all hash indexes coincide
      a = 32'h0123_4560;
      b = a ^ 32'h0000_0401;
      chk("R11 collision pair", {31'd0, bmask(a) == bmask(b)}, 32'd1);
      nm_put(a, 1'b1);
      host_put(b);
      commit_chunk("R11 false positive", 1'b0, '0, 1'b0, '0);

      // R2 sweep of generated addresses
      for (int t = 0; t < 300; t++) begin
         seed = next_rand(seed); a = seed;
         seed = next_rand(seed); b = seed;
         seed = next_rand(seed); c = seed;
         if (t % 3 == 0) b = (t % 2 == 0) ? a : c;
         nm_put(a, 1'b0);
         nm_put(c, 1'b1);
         host_put(b);
         commit_chunk("R2 hash sweep", 1'b0, '0, 1'b0, '0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule